// File: doc/BRIEF.md
# Protection Key Access Checker

This block decides whether a data access may proceed, using a small key held in the translated page entry instead of permission bits in the entry. A per-thread rights word holds two disable bits for every key. Software changes the protections of whole groups of pages by rewriting this word, and the page tables stay untouched.

On each lookup the requester presents the entry's key, the access kind and whether the core is in 64-bit mode. The block answers in the same cycle with allow or fault, and it names the disable bit that caused a fault. A read port and a write port give direct access to the rights word, matching the dedicated read and write operations. Page walking, translation caching, fault delivery and saving the word across thread switches belong to other blocks.

The block has no sequencing states. Its only storage is the rights word, which holds its value until a write replaces it at the next clock edge. All decisions are combinational from that word and the lookup inputs.

Top module: `pkey_access_checker`

## Requirements
- R1: After reset the rights word reads as all zeros, so every key carries no restriction.
- R2: When `rights_wr_en` is high at a rising clock edge, `rights_rd_data` shows `rights_wr_data` from that edge on. Without a write the word keeps its value.
- R3: A lookup made in the same cycle as a rights write is judged against the word held before that write.
- R4: For key k, bit 2k of the rights word is access-disable. A data read (`lk_kind` = 2'b00) in 64-bit mode faults exactly when that bit is set, and reports cause 2'b01.
- R5: Bit 2k+1 of the rights word is write-disable for key k. A data write (`lk_kind` = 2'b01) in 64-bit mode faults when access-disable or write-disable is set. The cause is 2'b01 when access-disable is set and 2'b10 when only write-disable is set.
- R6: An instruction fetch (`lk_kind` = 2'b10 or 2'b11) never faults, whatever the rights word holds.
- R7: When `mode_64` is low, no lookup faults.
- R8: When `lk_valid` is low, `lk_fault` and `lk_allow` are low and `lk_cause` is 2'b00.
- R9: When `lk_valid` is high, `lk_allow` is the inverse of `lk_fault`. `lk_cause` is 2'b00 exactly when there is no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_key | input | 4 | Protection key from the translated entry |
| lk_kind | input | 2 | 00 data read, 01 data write, 1x instruction fetch |
| mode_64 | input | 1 | High when the core runs in 64-bit mode |
| rights_wr_en | input | 1 | Rights word write strobe |
| rights_wr_data | input | 32 | New rights word |
| rights_rd_data | output | 32 | Current rights word |
| lk_allow | output | 1 | Lookup permitted |
| lk_fault | output | 1 | Lookup refused |
| lk_cause | output | 2 | 01 access-disable, 10 write-disable, 00 none |

## Verification
The assertions check the following on every cycle:
- fetch and non-64-bit exemptions;
- quiet outputs while no lookup is presented;
- consistency between allow, fault and cause;
- update and hold of the rights word;
- the read-fault rule, against the rights word seen at the port.

Some behaviour only the bench scenarios can show. One case is the write-versus-lookup race in a single cycle. The others are the priority of access-disable over write-disable on data writes, and agreement with an independent model across random keys, kinds and rights patterns.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

    typedef enum logic [1:0] {
        ACC_READ   = 2'b00,
        ACC_WRITE  = 2'b01,
        ACC_FETCH  = 2'b10,
        ACC_FETCH2 = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_ACCESS = 2'b01,
        CAUSE_WRITE  = 2'b10
    } fault_cause_e;

endpackage

// File: rtl/pkey_rights_reg.sv
module pkey_rights_reg #(
    parameter int RIGHTS_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [RIGHTS_W-1:0] wr_data,
    output logic [RIGHTS_W-1:0] rights_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rights_q <= '0;
        end else if (wr_en) begin
            rights_q <= wr_data;
        end
    end

endmodule

// File: rtl/pkey_key_select.sv
module pkey_key_select #(
    parameter int KEY_W = 4
) (
    input  logic [(2*(1<<KEY_W))-1:0] rights,
    input  logic [KEY_W-1:0]          key,
    output logic                      acc_dis,
    output logic                      wr_dis
);

    localparam int NUM_KEYS = 1 << KEY_W;

    logic [NUM_KEYS-1:0] acc_vec;
    logic [NUM_KEYS-1:0] wr_vec;

    // Even bit of each pair disables all data access, odd bit disables writes.
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_split
        assign acc_vec[k] = rights[2*k];
        assign wr_vec[k]  = rights[2*k+1];
    end

    assign acc_dis = acc_vec[key];
    assign wr_dis  = wr_vec[key];

endmodule

// File: rtl/pkey_verdict.sv
module pkey_verdict
    import pkey_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] kind,
    input  logic       mode_64,
    input  logic       acc_dis,
    input  logic       wr_dis,
    output logic       allow,
    output logic       fault,
    output logic [1:0] cause
);

    fault_cause_e cause_c;
    acc_kind_e    kind_e;

    assign kind_e = acc_kind_e'(kind);

    always_comb begin
        cause_c = CAUSE_NONE;
        if (valid && mode_64) begin
            unique case (kind_e)
                ACC_READ: begin
                    if (acc_dis) cause_c = CAUSE_ACCESS;
                end
                ACC_WRITE: begin
                    if (acc_dis)     cause_c = CAUSE_ACCESS;
                    else if (wr_dis) cause_c = CAUSE_WRITE;
                end
                ACC_FETCH, ACC_FETCH2: begin
                    cause_c = CAUSE_NONE;
                end
            endcase
        end
    end

    assign cause = cause_c;
    assign fault = (cause_c != CAUSE_NONE);
    assign allow = valid && (cause_c == CAUSE_NONE);

endmodule

// File: rtl/pkey_access_checker.sv
module pkey_access_checker #(
    parameter int KEY_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              lk_valid,
    input  logic [KEY_W-1:0]                  lk_key,
    input  logic [1:0]                        lk_kind,
    input  logic                              mode_64,
    input  logic                              rights_wr_en,
    input  logic [(2*(1<<KEY_W))-1:0]         rights_wr_data,
    output logic [(2*(1<<KEY_W))-1:0]         rights_rd_data,
    output logic                              lk_allow,
    output logic                              lk_fault,
    output logic [1:0]                        lk_cause
);

    localparam int NUM_KEYS = 1 << KEY_W;
    localparam int RIGHTS_W = 2 * NUM_KEYS;

    logic [RIGHTS_W-1:0] rights_q;
    logic                sel_acc_dis;
    logic                sel_wr_dis;

    pkey_rights_reg #(.RIGHTS_W(RIGHTS_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rights_wr_en),
        .wr_data  (rights_wr_data),
        .rights_q (rights_q)
    );

    pkey_key_select #(.KEY_W(KEY_W)) u_sel (
        .rights  (rights_q),
        .key     (lk_key),
        .acc_dis (sel_acc_dis),
        .wr_dis  (sel_wr_dis)
    );

    pkey_verdict u_verdict (
        .valid   (lk_valid),
        .kind    (lk_kind),
        .mode_64 (mode_64),
        .acc_dis (sel_acc_dis),
        .wr_dis  (sel_wr_dis),
        .allow   (lk_allow),
        .fault   (lk_fault),
        .cause   (lk_cause)
    );

    assign rights_rd_data = rights_q;

endmodule

// File: rtl/pkey_checker_sva.sv
module pkey_checker_sva #(
    parameter int KEY_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      lk_valid,
    input logic [KEY_W-1:0]          lk_key,
    input logic [1:0]                lk_kind,
    input logic                      mode_64,
    input logic                      rights_wr_en,
    input logic [(2*(1<<KEY_W))-1:0] rights_wr_data,
    input logic [(2*(1<<KEY_W))-1:0] rights_rd_data,
    input logic                      lk_allow,
    input logic                      lk_fault,
    input logic [1:0]                lk_cause
);

    p_wr_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rights_wr_en |=> rights_rd_data == $past(rights_wr_data));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rights_wr_en |=> $stable(rights_rd_data));

    p_read_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && mode_64 && lk_kind == 2'b00) |->
            (lk_fault == rights_rd_data[{lk_key, 1'b0}]));

    p_write_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && mode_64 && lk_kind == 2'b01 && rights_rd_data[{lk_key, 1'b1}]
         && !rights_rd_data[{lk_key, 1'b0}]) |-> (lk_cause == 2'b10));

    p_fetch_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind[1]) |-> !lk_fault);

    p_mode_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !mode_64) |-> !lk_fault);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_fault && !lk_allow && lk_cause == 2'b00));

    p_allow_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_allow != lk_fault));

    p_cause_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_cause) && (lk_fault == (lk_cause != 2'b00)));

endmodule

bind pkey_access_checker pkey_checker_sva #(.KEY_W(KEY_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_key         (lk_key),
    .lk_kind        (lk_kind),
    .mode_64        (mode_64),
    .rights_wr_en   (rights_wr_en),
    .rights_wr_data (rights_wr_data),
    .rights_rd_data (rights_rd_data),
    .lk_allow       (lk_allow),
    .lk_fault       (lk_fault),
    .lk_cause       (lk_cause)
);

// File: tb/tb_pkey_access_checker.sv
module tb_pkey_access_checker;

    localparam int KEY_W    = 4;
    localparam int RIGHTS_W = 2 * (1 << KEY_W);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                lk_valid = 1'b0;
    logic [KEY_W-1:0]    lk_key = '0;
    logic [1:0]          lk_kind = 2'b00;
    logic                mode_64 = 1'b0;
    logic                rights_wr_en = 1'b0;
    logic [RIGHTS_W-1:0] rights_wr_data = '0;
    logic [RIGHTS_W-1:0] rights_rd_data;
    logic                lk_allow;
    logic                lk_fault;
    logic [1:0]          lk_cause;

    int checks = 0;
    int fails  = 0;
    logic [RIGHTS_W-1:0] model_rights = '0;

    always #4 clk = ~clk;

    pkey_access_checker #(.KEY_W(KEY_W)) dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_key(lk_key),
        .lk_kind(lk_kind), .mode_64(mode_64), .rights_wr_en(rights_wr_en),
        .rights_wr_data(rights_wr_data), .rights_rd_data(rights_rd_data),
        .lk_allow(lk_allow), .lk_fault(lk_fault), .lk_cause(lk_cause)
    );

    function automatic logic [1:0] exp_cause(logic [RIGHTS_W-1:0] r, logic [KEY_W-1:0] k,
                                             logic [1:0] kind, logic m64, logic v);
        logic ad;
        logic wd;
        ad = r[2*k];
        wd = r[2*k+1];
        if (!v || !m64 || kind[1]) return 2'b00;
        if (ad) return 2'b01;
        if (kind == 2'b01 && wd) return 2'b10;
        return 2'b00;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check outputs of the current cycle against the model, then let the edge pass.
    task automatic step(string req, logic v, logic [KEY_W-1:0] k, logic [1:0] kind, logic m64,
                        logic we, logic [RIGHTS_W-1:0] wd);
        logic [1:0] ec;
        @(negedge clk);
        lk_valid = v; lk_key = k; lk_kind = kind; mode_64 = m64;
        rights_wr_en = we; rights_wr_data = wd;
        #1;
        ec = exp_cause(model_rights, k, kind, m64, v);
        chk({req, " cause"}, 64'(lk_cause), 64'(ec));
        chk({req, " fault"}, 64'(lk_fault), 64'(ec != 2'b00));
        chk({req, " allow R9"}, 64'(lk_allow), 64'(v && ec == 2'b00));
        chk({req, " rd R2"}, 64'(rights_rd_data), 64'(model_rights));
        @(posedge clk);
        if (we) model_rights = wd;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [RIGHTS_W-1:0] pat;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset rights", 64'(rights_rd_data), 64'd0);
        chk("R8 idle fault", 64'(lk_fault), 64'd0);

        // key 3: access-disable (bit 6); key 5: write-disable (bit 11)
        pat = '0;
        pat[6]  = 1'b1;
        pat[11] = 1'b1;
        step("R3 same-cycle write", 1'b1, 4'd3, 2'b00, 1'b1, 1'b1, pat);
        chk("R3 no fault with old word", 64'(lk_fault), 64'd0);
        step("R2 written word", 1'b0, 4'd0, 2'b00, 1'b1, 1'b0, '0);
        step("R4 read key3 AD", 1'b1, 4'd3, 2'b00, 1'b1, 1'b0, '0);
        step("R5 write key3 AD", 1'b1, 4'd3, 2'b01, 1'b1, 1'b0, '0);
        step("R5 read key5 WD ok", 1'b1, 4'd5, 2'b00, 1'b1, 1'b0, '0);
        step("R5 write key5 WD", 1'b1, 4'd5, 2'b01, 1'b1, 1'b0, '0);
        step("R6 fetch key3", 1'b1, 4'd3, 2'b10, 1'b1, 1'b0, '0);
        step("R6 fetch alt key3", 1'b1, 4'd3, 2'b11, 1'b1, 1'b0, '0);
        step("R7 mode off key3", 1'b1, 4'd3, 2'b01, 1'b0, 1'b0, '0);
        step("R8 no strobe key3", 1'b0, 4'd3, 2'b00, 1'b1, 1'b0, '0);
        step("R5 both bits all", 1'b1, 4'd15, 2'b01, 1'b1, 1'b1, '1);
        step("R5 AD priority", 1'b1, 4'd15, 2'b01, 1'b1, 1'b0, '0);

        for (int i = 0; i < 3000; i++) begin
            logic we;
            we = ($urandom % 5) == 0;
            step("R4/R5 random", ($urandom % 4) != 0, KEY_W'($urandom), 2'($urandom),
                 ($urandom % 5) != 0, we, RIGHTS_W'($urandom));
        end
        finish_run();
    end

endmodule